// File: doc/BRIEF.md
# Constant Fill DMA Engine

This block carries out one kind of queued DMA command: filling a stretch of memory with a constant byte value. A queue front end offers a 32-bit command header and a 128-bit command body. The engine accepts them with a valid/ready handshake. From the header it takes an element-size exponent. From the body it takes the destination address, the fill data word and an element count. It works out the total byte length and advances its queue read pointer past the 16-byte body.

The engine then walks the destination range. It issues one memory write request per chunk, and no chunk ever crosses a page boundary. This matters because neighbouring pages need not be physically contiguous. Only one chunk is in flight at a time. Each chunk must be acknowledged before the next one is issued.

When the acknowledge for the last chunk arrives, the engine pulses `done` and drops `busy`. From that point the next command can be taken.

Top module: `cfill_engine`

## Requirements
- R1: Header decode. The element-size exponent is header bits [31:30]. Header bits [29:0] (command code, sub-code, swap bits [17:16] and reserved bits) have no effect on the writes issued.
- R2: Total bytes. The body holds the address in bits [ADDR_W-1:0], the data word in bits [95:64] and the count in bits [96+CNT_W-1:96]. The bytes written in total equal (count+1) shifted left by the size exponent.
- R3: Chunking. The first chunk starts at the command address and runs to the next page boundary or to the end of the range, whichever is nearer. Each later chunk starts where the previous one ended, with the address wrapping modulo 2^ADDR_W. No chunk crosses a page boundary and no chunk is empty.
- R4: Fill value. Every write request carries the least significant byte of the data word (body bits [71:64]).
- R5: Request hold. While `wr_valid` is high and `wr_ready` is low, the request stays asserted and its address, length and byte stay unchanged.
- R6: Single outstanding write. After a request is accepted, `wr_valid` stays low until a `wr_ack` pulse arrives.
- R7: Completion. `done` is high for exactly one cycle, the cycle after the `wr_ack` of the last chunk. In that cycle `busy` is already low. `done` stays low at all other times.
- R8: Busy and exclusion. `busy` rises the cycle after a command is accepted and stays high until completion. `cmd_ready` is low while busy. A command offered while busy is ignored: the read pointer and the writes in progress are unchanged.
- R9: Read pointer. `rptr` advances by 16 (the body size in bytes), modulo 2^PTR_W, in the cycle after each accepted command.
- R10: Reset state. After reset: `busy`=0, `cmd_ready`=1, `wr_valid`=0, `done`=0, `rptr`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine idle, command taken when valid |
| cmd_header | input | 32 | Command header word |
| cmd_body | input | 128 | Command body: address, data word, count |
| rptr | output | PTR_W | Queue read pointer in bytes |
| wr_valid | output | 1 | Write request valid |
| wr_ready | input | 1 | Write request accepted |
| wr_addr | output | ADDR_W | Chunk start address |
| wr_len | output | log2(PAGE_BYTES)+1 | Chunk length in bytes |
| wr_byte | output | 8 | Byte value to write across the chunk |
| wr_ack | input | 1 | Single-cycle write-completion pulse |
| busy | output | 1 | Command in progress |
| done | output | 1 | Single-cycle completion pulse |

## Verification
The bench builds the engine with a 16-byte page, a 12-bit address and a 6-bit count. With these values a single command can span up to 33 pages, and every start offset within a page is within reach. It sweeps all four size exponents, all 16 page offsets and a spread of counts from a single element to the largest count. For each command it computes the expected chunk addresses and lengths arithmetically. It also runs an address near the top of the 12-bit space, so the wrap to zero is exercised. Along the way it inserts ready stalls and offers a command while the engine is busy.

// File: rtl/cfill_pkg.sv
package cfill_pkg;

    localparam int BODY_BYTES = 16;
    localparam int BODY_W     = 8 * BODY_BYTES;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } cfill_state_e;

    typedef struct packed {
        logic [1:0]  elem_log2;
        logic [11:0] rsvd;
        logic [1:0]  swap;
        logic [7:0]  sub_code;
        logic [7:0]  cmd_code;
    } cfill_hdr_t;

endpackage

// File: rtl/cfill_decode.sv
module cfill_decode
    import cfill_pkg::*;
#(
    parameter int ADDR_W = 48,
    parameter int CNT_W  = 32,
    parameter int LEN_W  = CNT_W + 4
) (
    input  logic [31:0]       hdr_i,
    input  logic [BODY_W-1:0] body_i,
    output logic [ADDR_W-1:0] dst_addr_o,
    output logic [7:0]        fill_byte_o,
    output logic [LEN_W-1:0]  total_len_o
);

    cfill_hdr_t       hdr;
    logic [CNT_W-1:0] count;
    logic [LEN_W-1:0] elems;
    logic             unused_fields;

    assign hdr         = cfill_hdr_t'(hdr_i);
    assign dst_addr_o  = body_i[ADDR_W-1:0];
    assign fill_byte_o = body_i[71:64];
    assign count       = body_i[96 +: CNT_W];

    always_comb begin
        elems       = LEN_W'(count) + LEN_W'(1);
        total_len_o = elems << hdr.elem_log2;
    end

    assign unused_fields = ^{hdr_i, body_i};

endmodule

// File: rtl/cfill_chunker.sv
module cfill_chunker #(
    parameter int ADDR_W     = 48,
    parameter int LEN_W      = 36,
    parameter int PAGE_BYTES = 4096,
    localparam int PG_SH     = $clog2(PAGE_BYTES),
    localparam int PGL_W     = PG_SH + 1
) (
    input  logic [ADDR_W-1:0] cur_addr_i,
    input  logic [LEN_W-1:0]  remain_i,
    output logic [PGL_W-1:0]  chunk_len_o,
    output logic              chunk_last_o
);

    logic [PGL_W-1:0] room;
    logic             unused_addr;

    always_comb begin
        room = PGL_W'(PAGE_BYTES) - PGL_W'(cur_addr_i[PG_SH-1:0]);
        if (remain_i <= LEN_W'(room)) begin
            chunk_len_o  = PGL_W'(remain_i);
            chunk_last_o = 1'b1;
        end else begin
            chunk_len_o  = room;
            chunk_last_o = 1'b0;
        end
    end

    assign unused_addr = ^cur_addr_i;

endmodule

// File: rtl/cfill_engine.sv
module cfill_engine
    import cfill_pkg::*;
#(
    parameter int ADDR_W     = 48,
    parameter int CNT_W      = 32,
    parameter int PAGE_BYTES = 4096,
    parameter int PTR_W      = 32,
    localparam int PG_SH     = $clog2(PAGE_BYTES),
    localparam int PGL_W     = PG_SH + 1,
    localparam int LEN_W     = CNT_W + 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [31:0]       cmd_header,
    input  logic [BODY_W-1:0] cmd_body,
    output logic [PTR_W-1:0]  rptr,
    output logic              wr_valid,
    input  logic              wr_ready,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [PGL_W-1:0]  wr_len,
    output logic [7:0]        wr_byte,
    input  logic              wr_ack,
    output logic              busy,
    output logic              done
);

    typedef struct packed {
        cfill_state_e      state;
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  remain;
        logic [7:0]        fbyte;
        logic [PGL_W-1:0]  clen;
        logic              clast;
        logic [PTR_W-1:0]  rptr;
        logic              done;
    } regs_t;

    regs_t r_d, r_q;

    logic [ADDR_W-1:0] dec_addr;
    logic [7:0]        dec_byte;
    logic [LEN_W-1:0]  dec_len;
    logic [PGL_W-1:0]  chunk_len;
    logic              chunk_last;

    cfill_decode #(
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W),
        .LEN_W  (LEN_W)
    ) i_decode (
        .hdr_i       (cmd_header),
        .body_i      (cmd_body),
        .dst_addr_o  (dec_addr),
        .fill_byte_o (dec_byte),
        .total_len_o (dec_len)
    );

    cfill_chunker #(
        .ADDR_W     (ADDR_W),
        .LEN_W      (LEN_W),
        .PAGE_BYTES (PAGE_BYTES)
    ) i_chunker (
        .cur_addr_i   (r_q.addr),
        .remain_i     (r_q.remain),
        .chunk_len_o  (chunk_len),
        .chunk_last_o (chunk_last)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (cmd_valid) begin
                    r_d.addr   = dec_addr;
                    r_d.remain = dec_len;
                    r_d.fbyte  = dec_byte;
                    r_d.rptr   = r_q.rptr + PTR_W'(BODY_BYTES);
                    r_d.state  = ST_ISSUE;
                end
            end
            ST_ISSUE: begin
                if (wr_ready) begin
                    r_d.clen  = chunk_len;
                    r_d.clast = chunk_last;
                    r_d.state = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (wr_ack) begin
                    if (r_q.clast) begin
                        r_d.state = ST_IDLE;
                        r_d.done  = 1'b1;
                    end else begin
                        r_d.addr   = r_q.addr + ADDR_W'(r_q.clen);
                        r_d.remain = r_q.remain - LEN_W'(r_q.clen);
                        r_d.state  = ST_ISSUE;
                    end
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign cmd_ready = (r_q.state == ST_IDLE);
    assign busy      = (r_q.state != ST_IDLE);
    assign wr_valid  = (r_q.state == ST_ISSUE);
    assign wr_addr   = r_q.addr;
    assign wr_len    = chunk_len;
    assign wr_byte   = r_q.fbyte;
    assign rptr      = r_q.rptr;
    assign done      = r_q.done;

    // R3
    page_cross_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> (wr_len != '0) &&
            ((int'(wr_addr[PG_SH-1:0]) + int'(wr_len)) <= PAGE_BYTES));

    // R5
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> wr_valid && $stable(wr_addr) &&
            $stable(wr_len) && $stable(wr_byte));

    // R6
    one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_ready) |=> !wr_valid);

    // R7
    done_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(wr_ack) && !busy);

    // R8
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> busy);

    // R9
    rptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> rptr == $past(rptr) + PTR_W'(BODY_BYTES));

endmodule

// File: tb/test_cfill_engine.sv
module test_cfill_engine;

    localparam int ADDR_W = 12;
    localparam int CNT_W  = 6;
    localparam int PAGE   = 16;
    localparam int PTR_W  = 16;
    localparam int PGL_W  = 5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cmd_valid = 1'b0;
    logic              cmd_ready;
    logic [31:0]       cmd_header = '0;
    logic [127:0]      cmd_body = '0;
    logic [PTR_W-1:0]  rptr;
    logic              wr_valid;
    logic              wr_ready = 1'b0;
    logic [ADDR_W-1:0] wr_addr;
    logic [PGL_W-1:0]  wr_len;
    logic [7:0]        wr_byte;
    logic              wr_ack = 1'b0;
    logic              busy;
    logic              done;

    int checks = 0;
    int errors = 0;
    int exp_rptr = 0;

    always #10 clk = ~clk;

    cfill_engine #(
        .ADDR_W     (ADDR_W),
        .CNT_W      (CNT_W),
        .PAGE_BYTES (PAGE),
        .PTR_W      (PTR_W)
    ) i_cfill_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .cmd_ready  (cmd_ready),
        .cmd_header (cmd_header),
        .cmd_body   (cmd_body),
        .rptr       (rptr),
        .wr_valid   (wr_valid),
        .wr_ready   (wr_ready),
        .wr_addr    (wr_addr),
        .wr_len     (wr_len),
        .wr_byte    (wr_byte),
        .wr_ack     (wr_ack),
        .busy       (busy),
        .done       (done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_cmd(input int sz, input int a, input int cnt,
                           input logic [31:0] dw, input logic [1:0] sw,
                           input int stall, input bit poke);
        int rem;
        int ad;
        int elen;
        int total;
        bit first;
        logic [ADDR_W-1:0] h_addr;
        logic [PGL_W-1:0]  h_len;
        total = (cnt + 1) << sz;
        rem   = total;
        ad    = a;
        first = 1'b1;
        // R1: reserved, swap and code bits filled with varying junk
        cmd_header = {sz[1:0], 12'(a * 7 + cnt), sw, 8'(cnt), 8'(a)};
        cmd_body   = {32'(cnt), dw, 32'h0, 32'(a)};
        chk(cmd_ready == 1'b1, "R8 ready when idle", int'(cmd_ready), 1);
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        exp_rptr = (exp_rptr + 16) % (1 << PTR_W);
        chk(int'(rptr) == exp_rptr, "R9 rptr step", int'(rptr), exp_rptr);
        chk(busy == 1'b1, "R8 busy after accept", int'(busy), 1);
        while (rem > 0) begin
            elen = PAGE - (ad % PAGE);
            if (rem < elen) elen = rem;
            if (poke && first) begin
                cmd_valid  = 1'b1;
                cmd_header = 32'hC000_0000;
                cmd_body   = {32'd50, 32'h0000_00EE, 32'h0, 32'h0000_0123};
            end
            chk(wr_valid == 1'b1, "R6 request issued", int'(wr_valid), 1);
            h_addr = wr_addr;
            h_len  = wr_len;
            for (int s = 0; s < stall; s++) begin
                @(negedge clk);
                chk(wr_valid && wr_addr == h_addr && wr_len == h_len,
                    "R5 hold under stall", int'(wr_addr), int'(h_addr));
            end
            chk(int'(wr_addr) == ad, "R3 chunk address", int'(wr_addr), ad);
            chk(int'(wr_len) == elen, "R3 chunk length", int'(wr_len), elen);
            chk(wr_byte == dw[7:0], "R4 fill byte", int'(wr_byte), int'(dw[7:0]));
            if (poke && first) begin
                chk(cmd_ready == 1'b0, "R8 not ready while busy", int'(cmd_ready), 0);
            end
            wr_ready = 1'b1;
            @(negedge clk);
            wr_ready = 1'b0;
            chk(wr_valid == 1'b0, "R6 no second request", int'(wr_valid), 0);
            @(negedge clk);
            chk(wr_valid == 1'b0, "R6 waits for ack", int'(wr_valid), 0);
            chk(done == 1'b0, "R7 no early done", int'(done), 0);
            wr_ack = 1'b1;
            @(negedge clk);
            wr_ack    = 1'b0;
            cmd_valid = 1'b0;
            rem   = rem - elen;
            ad    = (ad + elen) % (1 << ADDR_W);
            first = 1'b0;
            if (rem == 0) begin
                chk(done == 1'b1 && busy == 1'b0, "R7 done after last ack",
                    int'({done, busy}), 2);
            end else begin
                chk(done == 1'b0 && busy == 1'b1, "R7 busy mid fill",
                    int'({done, busy}), 1);
            end
        end
        @(negedge clk);
        chk(done == 1'b0, "R7 single-cycle done", int'(done), 0);
        // R2: byte total is implied by the chunk walk ending exactly here
        chk(((ad - a + (1 << ADDR_W)) % (1 << ADDR_W)) == total % (1 << ADDR_W),
            "R2 total bytes", (ad - a + (1 << ADDR_W)) % (1 << ADDR_W), total);
        chk(int'(rptr) == exp_rptr, "R8 busy offer ignored", int'(rptr), exp_rptr);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", checks, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int cnts[6] = '{0, 1, 3, 7, 20, 63};
        repeat (3) @(negedge clk);
        // R10
        chk(busy == 1'b0 && cmd_ready == 1'b1 && wr_valid == 1'b0 &&
            done == 1'b0 && rptr == '0, "R10 reset state",
            int'({busy, cmd_ready, wr_valid, done}), 4);
        rst_n = 1'b1;
        @(negedge clk);
        for (int sz = 0; sz < 4; sz++) begin
            for (int off = 0; off < PAGE; off++) begin
                for (int ci = 0; ci < 6; ci++) begin
                    run_cmd(sz, 16 * (ci + 3 * sz) + off, cnts[ci],
                            32'h1234_5600 | 32'((sz * 16 + off + ci * 37) & 8'hFF),
                            2'(off), off % 3, off == 5 && ci >= 2);
                end
            end
        end
        // R3: wrap of the address space
        run_cmd(0, 4093, 7, 32'hABCD_EF5A, 2'b11, 1, 1'b0);
        run_cmd(3, 4090, 2, 32'h0000_00C3, 2'b01, 0, 1'b1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule